// File: doc/BRIEF.md
# Four-Lane Leading-Edge Marker and Word Packer

This block sits behind a set of 1-bit comparators that watch the quadrants of a photon-counting detector. Each comparator gives one binary sample per fast clock. A single detector pulse can stay high for several samples, and counting every high sample would count too many photons. Each lane therefore turns every pulse into a one-sample marker on the sample where the pulse starts. The lanes are judged separately, so pulses on different lanes may overlap in time. Only starts that fall on the very same sample run together.

The per-lane markers are merged into one serial mark stream with a logical OR. That stream is packed into parallel words of sixteen samples, so a slower processor can take one word for every sixteen fast clocks. A one-cycle strobe marks each new word. The word then holds its value until the next strobe.

Lane count, word width and bit order are parameters. The defaults are four lanes, sixteen-bit words and the oldest sample in the least significant bit.

Top module: `pulse_edge_combiner`

## Requirements
- R1: While rst_n is low, word_out is all zeros and word_vld is 0. Every lane's remembered previous sample is cleared to 0.
- R2: A lane produces a mark on a sample where its input is 1 and that same lane's previous sample was 0. It produces no mark on any other sample.
- R3: A pulse that stays high for several consecutive samples on one lane produces exactly one mark, at its first high sample.
- R4: Lanes are judged independently. Overlapping pulses on different lanes whose first high samples differ produce one mark each.
- R5: Pulse starts on several lanes in the same sample produce a single 1 in that sample's bit position.
- R6: Each lane keeps its previous sample across word boundaries. An input that was already high on the last sample of one word produces no mark on bit 0 of the next word.
- R7: With the default order, bit i of word_out holds the mark of the i-th of 16 consecutive samples, so bit 0 is the oldest and bit 15 the newest.
- R8: word_vld is high for exactly one cycle per 16 samples. The first pulse comes in the cycle after the 16th sample clocked after reset is released.
- R9: An input that is already high when reset is released produces a mark on the first sample after reset.
- R10: word_out changes only in a cycle where word_vld is high, and otherwise holds the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock; one sample per lane per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | NUM_CH (4) | One comparator sample per lane |
| word_out | output | WORD_W (16) | Packed marks of the last 16 samples |
| word_vld | output | 1 | One-cycle pulse when a new word_out is presented |

## Verification
A sample applied before rising edge k reaches the packer at that same edge, because edge detection and the OR need no register of their own. If it is the 16th sample of its group, word_vld and the finished word appear in the cycle after edge k and stay until edge k+1. The bench drives each sample just after a falling edge. It then waits one rising and one falling edge, and compares word_vld and word_out on every cycle with a behavioural model that queues the expected marks. Directed words are also checked against fixed constants in the strobe cycle: a held pulse, simultaneous starts, overlapping lanes, a pulse that crosses a word boundary, the bit order, and a lane that is high at reset.

// File: rtl/pec_pkg.sv
package pec_pkg;
   // Default geometry for the quad-lane marker packer
   localparam int unsigned DEF_LANES  = 4;
   localparam int unsigned DEF_WORD_W = 16;

   // Bit order inside an output word
   typedef enum logic {
      ORDER_OLDEST_MSB = 1'b0,
      ORDER_OLDEST_LSB = 1'b1
   } pec_order_e;
endpackage

// File: rtl/pec_edge_lane.sv
module pec_edge_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   output logic mark
);
   logic prev_q;

   // Previous sample of this lane; cleared by reset so a line high at
   // release is seen as a start on the first sample.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= smp;
   end

   assign mark = smp & ~prev_q;
endmodule

// File: rtl/pec_merge.sv
module pec_merge #(
   parameter int unsigned LANES = 4
) (
   input  logic [LANES-1:0] marks,
   output logic             merged
);
   // Reduction OR of the per-lane markers
   assign merged = |marks;
endmodule

// File: rtl/pec_pack.sv
module pec_pack
   import pec_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter pec_order_e  ORDER  = ORDER_OLDEST_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld
);
   localparam int unsigned    CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] shift_nxt;
   logic [WORD_W-1:0] word_q;
   logic              vld_q;

   generate
      if (ORDER == ORDER_OLDEST_LSB) begin : g_lsb
         // Newest enters at the top, oldest drifts to bit 0
         assign shift_nxt = {bit_in, shreg_q[WORD_W-1:1]};
      end else begin : g_msb
         assign shift_nxt = {shreg_q[WORD_W-2:0], bit_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shreg_q <= '0;
         word_q  <= '0;
         vld_q   <= 1'b0;
      end else begin
         shreg_q <= shift_nxt;
         vld_q   <= (cnt_q == LAST);
         if (cnt_q == LAST) begin
            word_q <= shift_nxt;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign word_out = word_q;
   assign word_vld = vld_q;
endmodule

// File: rtl/pulse_edge_combiner.sv
module pulse_edge_combiner
   import pec_pkg::*;
#(
   parameter int unsigned NUM_CH = DEF_LANES,
   parameter int unsigned WORD_W = DEF_WORD_W,
   parameter pec_order_e  ORDER  = ORDER_OLDEST_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] smp_in,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld
);
   // Elaboration-time parameter checks
   initial begin
      assert (NUM_CH >= 1) else $fatal(1, "NUM_CH must be at least 1");
      assert (WORD_W >= 2) else $fatal(1, "WORD_W must be at least 2");
   end

   logic [NUM_CH-1:0] lane_mark;
   logic              mark_stream;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
         pec_edge_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .smp   (smp_in[g]),
            .mark  (lane_mark[g])
         );
      end
   endgenerate

   pec_merge #(.LANES(NUM_CH)) u_merge (
      .marks  (lane_mark),
      .merged (mark_stream)
   );

   pec_pack #(.WORD_W(WORD_W), .ORDER(ORDER)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_in   (mark_stream),
      .word_out (word_out),
      .word_vld (word_vld)
   );
endmodule

// File: rtl/pec_checks.sv
module pec_checks #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] smp_in,
   input logic [WORD_W-1:0] word_out,
   input logic              word_vld
);
   localparam int unsigned PH_W   = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam int unsigned ONES_W = $clog2(NUM_CH * WORD_W + 1) + 1;

   logic [PH_W-1:0]   phase_q;
   logic              wrap_q;
   logic [ONES_W-1:0] ones_acc_q;
   logic [ONES_W-1:0] ones_win_q;
   logic [ONES_W-1:0] ones_now;

   assign ones_now = ONES_W'($countones(smp_in));

   // Independent sample-phase counter and count of high input samples per window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= '0;
         wrap_q     <= 1'b0;
         ones_acc_q <= '0;
         ones_win_q <= '0;
      end else begin
         wrap_q <= (phase_q == PH_W'(WORD_W - 1));
         if (phase_q == PH_W'(WORD_W - 1)) begin
            phase_q    <= '0;
            ones_win_q <= ones_acc_q + ones_now;
            ones_acc_q <= '0;
         end else begin
            phase_q    <= phase_q + PH_W'(1);
            ones_acc_q <= ones_acc_q + ones_now;
         end
      end
   end

   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (word_vld == 1'b0 && word_out == '0));

   // R8
   cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld == wrap_q);

   // R8
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word_out));

   // R3
   mark_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> (ONES_W'($countones(word_out)) <= ones_win_q));
endmodule

bind pulse_edge_combiner pec_checks #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_in   (smp_in),
   .word_out (word_out),
   .word_vld (word_vld)
);

// File: tb/sim_pulse_edge_combiner.sv
`timescale 1ns/1ps
module sim_pulse_edge_combiner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  smp_in = 4'b0000;
   logic [15:0] word_out;
   logic        word_vld;

   int checks = 0;
   int errors = 0;

   // Behavioural reference state
   logic [3:0]  prev_m = 4'b0000;
   bit          mq[$];
   logic [15:0] last_word = 16'h0000;
   logic [3:0]  stim [16];

   always #10 clk = ~clk;

   pulse_edge_combiner u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_in   (smp_in),
      .word_out (word_out),
      .word_vld (word_vld)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one sample, advance the model, compare on the following cycle
   task automatic step(input logic [3:0] v, input string tag);
      logic        mk;
      logic        exp_v;
      logic [15:0] exp_w;
      smp_in = v;
      mk = |(v & ~prev_m);
      prev_m = v;
      mq.push_back(mk);
      exp_v = (mq.size() == 16);
      exp_w = last_word;
      if (exp_v) begin
         for (int i = 0; i < 16; i++) exp_w[i] = mq[i];
         mq.delete();
         last_word = exp_w;
      end
      @(posedge clk);
      @(negedge clk);
      chk({tag, "/R8 strobe"}, {31'd0, word_vld}, {31'd0, exp_v});
      chk({tag, exp_v ? "/R7 word" : "/R10 hold"}, {16'd0, word_out}, {16'd0, exp_w});
   endtask

   task automatic run_word(input string tag);
      for (int i = 0; i < 16; i++) step(stim[i], tag);
   endtask

   task automatic clear_stim;
      for (int i = 0; i < 16; i++) stim[i] = 4'b0000;
   endtask

   initial begin
      // R1 / R9: hold reset with lane 2 already high
      smp_in = 4'b0100;
      repeat (3) @(negedge clk);
      chk("R1 reset vld", {31'd0, word_vld}, 32'd0);
      chk("R1 reset word", {16'd0, word_out}, 32'd0);
      rst_n = 1'b1;

      // R9 / R3: lane 2 high from reset for 5 samples
      clear_stim;
      for (int i = 0; i < 5; i++) stim[i] = 4'b0100;
      run_word("R9");
      chk("R9 R3 first word", {16'd0, word_out}, 32'h0001);

      // R5: all lanes start together at sample 3
      clear_stim;
      stim[3] = 4'b1111; stim[4] = 4'b1111;
      run_word("R5");
      chk("R5 merged start", {16'd0, word_out}, 32'h0008);

      // R4: overlapping pulses on lanes 0 and 1
      clear_stim;
      for (int i = 2; i <= 8; i++)  stim[i][0] = 1'b1;
      for (int i = 4; i <= 10; i++) stim[i][1] = 1'b1;
      run_word("R4");
      chk("R4 overlap", {16'd0, word_out}, 32'h0014);

      // R6: lane 3 rises on the last sample and stays high into the next word
      clear_stim;
      stim[15] = 4'b1000;
      run_word("R6a");
      chk("R6 last bit", {16'd0, word_out}, 32'h8000);
      clear_stim;
      for (int i = 0; i <= 3; i++) stim[i] = 4'b1000;
      stim[9] = 4'b0001;
      run_word("R6b");
      chk("R6 no bit0 mark", {16'd0, word_out}, 32'h0200);

      // R7: bit order, lane 0 on even samples, lane 1 only on the newest
      clear_stim;
      for (int i = 0; i < 16; i += 2) stim[i] = 4'b0001;
      stim[15] = 4'b0010;
      run_word("R7");
      chk("R7 order", {16'd0, word_out}, 32'hD555);

      // R2: random activity compared with the model
      for (int w = 0; w < 8; w++) begin
         for (int i = 0; i < 16; i++) stim[i] = 4'($urandom_range(0, 15));
         run_word("R2 random");
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule